// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous page-mode DRAM refreshed. An interval timer marks one refresh as owed each time a programmable interval runs out. The default interval is sized so that 4096 distributed refreshes cover the whole array inside the 64 ms retention period. The owed refreshes are kept in a saturating counter. While any are owed, the block raises a request to the access sequencer. When it sees a grant, it takes over the strobes and runs one refresh cycle. That cycle is either a CAS-before-RAS cycle, where the device supplies the row, or a RAS-only cycle, where the block drives a row counter of its own onto the address bus.

For low-power standby, a self-refresh request makes the block run a burst of CAS-before-RAS cycles covering every row. It then goes straight into a CAS-before-RAS style entry and holds RAS low long enough that the device starts refreshing itself. When the request drops, the block releases the strobes for the exit precharge and runs a second full burst before it hands the bus back. Both bursts always use CAS-before-RAS, whatever refresh mode is selected. The interval timer is frozen for the whole self-refresh sequence and restarts from zero afterwards.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, ras_n_o, cas_n_o and we_n_o are high, and drive_o, req_o, urgent_o and sr_active_o are low. Whenever drive_o is low, RAS and CAS are high.
- R2: After reset, the first refresh becomes owed and req_o rises exactly INTERVAL clock cycles after reset is released. One more refresh becomes owed every INTERVAL cycles after that.
- R3: The owed count saturates at MAX_OWED. urgent_o is high exactly while the count equals MAX_OWED. With the grant held high, the block then runs exactly MAX_OWED refresh cycles and drops req_o.
- R4: In a CAS-before-RAS cycle, CAS goes low T_CSR cycles before RAS falls and stays low while RAS is low. RAS stays low for exactly T_RAS cycles, and WE stays high.
- R5: A RAS-only cycle (mode_row_i = 1) keeps CAS high. It drives the row counter on addr_o, steady while RAS is low. The counter rises by one after each RAS-only cycle and wraps to 0 after 2^ROW_BITS - 1.
- R6: The block never drives the strobes before a grant. While req_o is high and gnt_i is low, drive_o stays low and RAS and CAS stay high. req_o falls once the block takes the bus.
- R7: Each refresh cycle ends with T_RP cycles of RAS and CAS high before drive_o falls. drive_o is high for T_CSR + T_RAS + T_RP cycles in a CAS-before-RAS cycle and for T_RAS + T_RP cycles in a RAS-only cycle. RAS is never high for just one cycle between two RAS-low periods.
- R8: A granted self-refresh request (sr_req_i = 1) first runs 2^ROW_BITS back-to-back CAS-before-RAS cycles, even in RAS-only mode. It then lowers CAS and then RAS, and asserts sr_active_o after RAS has been low for T_SRE cycles. RAS and CAS stay low while sr_active_o is high.
- R9: When sr_req_i falls during self-refresh, sr_active_o falls with RAS and CAS going high. RAS stays high for at least T_RPS cycles. Then 2^ROW_BITS CAS-before-RAS cycles run before drive_o falls.
- R10: No refresh becomes owed during the self-refresh sequence. After the exit burst the owed count is zero, and req_o rises exactly INTERVAL cycles after drive_o falls.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_row_i | input | 1 | 1 selects RAS-only refresh for distributed cycles, 0 selects CAS-before-RAS |
| sr_req_i | input | 1 | Level request to enter and remain in self-refresh |
| gnt_i | input | 1 | Grant from the access sequencer, sampled while req_o is high |
| req_o | output | 1 | Bus request: a refresh is owed or self-refresh is wanted |
| urgent_o | output | 1 | Owed count at its ceiling; sequencer should grant at its next page close |
| drive_o | output | 1 | The block owns the strobes and address bus |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high (inactive) |
| addr_o | output | ROW_BITS | Row address for RAS-only refresh |
| sr_active_o | output | 1 | The device is held in self-refresh |

## Verification
The bench builds the block with ROW_BITS = 3, INTERVAL = 200, MAX_OWED = 4, T_CSR = 2, T_RAS = 6, T_RP = 4, T_SRE = 30 and T_RPS = 10. An eight-row array makes both self-refresh bursts short enough to count cycle by cycle. It also makes the RAS-only row counter wrap within nine cycles. The short interval lets owed refreshes pile past saturation in about a thousand cycles. T_CSR of two cycles shows that CAS setup is a real delay and not a single edge. An entry hold of thirty cycles keeps the self-refresh entry and the frozen timer within reach of a directed run.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSET,
        ST_RASLO,
        ST_PRE,
        ST_SR,
        ST_SR_EXIT
    } rfs_state_e;

    typedef enum logic [2:0] {
        K_CBR,
        K_ROW,
        K_BURST_IN,
        K_ENTRY,
        K_BURST_OUT
    } rfs_kind_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic drive;
        logic sr_active;
    } rfs_pins_t;

    // Strobe levels that belong to a given state and cycle kind.
    function automatic rfs_pins_t pins_for(rfs_state_e st, rfs_kind_e k);
        rfs_pins_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, drive: 1'b0, sr_active: 1'b0};
        case (st)
            ST_CSET:    begin p.cas_n = 1'b0; p.drive = 1'b1; end
            ST_RASLO:   begin
                p.ras_n = 1'b0;
                p.cas_n = (k == K_ROW);
                p.drive = 1'b1;
            end
            ST_PRE:     p.drive = 1'b1;
            ST_SR:      begin
                p.ras_n = 1'b0; p.cas_n = 1'b0;
                p.drive = 1'b1; p.sr_active = 1'b1;
            end
            ST_SR_EXIT: p.drive = 1'b1;
            default:    ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int INTERVAL = 3120
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        tick_o = 1'b0;
        if (clear_i) begin
            d.cnt = '0;
        end else if (!hold_i) begin
            if (q.cnt == LAST) begin
                d.cnt  = '0;
                tick_o = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/rfs_owed_counter.sv
module rfs_owed_counter #(
    parameter int MAX_OWED = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    input  logic dec_i,
    input  logic clear_i,
    output logic pending_o,
    output logic full_o
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] CEIL = OW'(MAX_OWED);

    typedef struct packed {
        logic [OW-1:0] owed;
    } owed_t;

    owed_t q, d;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.owed = '0;
        end else if (inc_i && !dec_i) begin
            if (q.owed != CEIL) d.owed = q.owed + 1'b1;
        end else if (dec_i && !inc_i) begin
            if (q.owed != '0) d.owed = q.owed - 1'b1;
        end
        pending_o = (q.owed != '0);
        full_o    = (q.owed == CEIL);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/rfs_strobe_fsm.sv
module rfs_strobe_fsm
    import rfs_pkg::*;
#(
    parameter int ROW_BITS = 12,
    parameter int T_CSR    = 1,
    parameter int T_RAS    = 12,
    parameter int T_RP     = 8,
    parameter int T_SRE    = 20100,
    parameter int T_RPS    = 22
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                mode_row_i,
    input  logic                sr_req_i,
    input  logic                gnt_i,
    input  logic                pending_i,
    output logic                req_o,
    output logic                done_o,
    output logic                clear_o,
    output logic                hold_o,
    output logic                ras_n_o,
    output logic                cas_n_o,
    output logic                drive_o,
    output logic                sr_active_o,
    output logic [ROW_BITS-1:0] addr_o
);
    localparam int M1   = (T_SRE > T_RAS) ? T_SRE : T_RAS;
    localparam int M2   = (T_RPS > T_RP) ? T_RPS : T_RP;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXT = (M3 > T_CSR) ? M3 : T_CSR;
    localparam int TW   = $clog2(MAXT + 1);

    localparam logic [TW-1:0] C_CSR = TW'(T_CSR - 1);
    localparam logic [TW-1:0] C_RAS = TW'(T_RAS - 1);
    localparam logic [TW-1:0] C_RP  = TW'(T_RP - 1);
    localparam logic [TW-1:0] C_SRE = TW'(T_SRE - 1);
    localparam logic [TW-1:0] C_RPS = TW'(T_RPS - 1);

    typedef struct packed {
        rfs_state_e          state;
        rfs_kind_e           kind;
        logic [TW-1:0]       cnt;
        logic [ROW_BITS-1:0] left;
        logic [ROW_BITS-1:0] row;
        rfs_pins_t           pins;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d       = q;
        d.cnt   = q.cnt + 1'b1;
        done_o  = 1'b0;
        clear_o = 1'b0;
        req_o   = (q.state == ST_IDLE) && (sr_req_i || pending_i);
        hold_o  = (q.state != ST_IDLE) &&
                  (q.kind == K_BURST_IN || q.kind == K_ENTRY || q.kind == K_BURST_OUT);

        case (q.state)
            ST_IDLE: begin
                d.cnt = '0;
                if (req_o && gnt_i) begin
                    if (sr_req_i) begin
                        d.kind  = K_BURST_IN;
                        d.left  = '1;
                        d.state = ST_CSET;
                    end else if (mode_row_i) begin
                        d.kind  = K_ROW;
                        d.state = ST_RASLO;
                    end else begin
                        d.kind  = K_CBR;
                        d.state = ST_CSET;
                    end
                end
            end
            ST_CSET: begin
                if (q.cnt == C_CSR) begin
                    d.cnt   = '0;
                    d.state = ST_RASLO;
                end
            end
            ST_RASLO: begin
                if (q.kind == K_ENTRY) begin
                    if (q.cnt == C_SRE) begin
                        d.cnt   = '0;
                        d.state = ST_SR;
                    end
                end else if (q.cnt == C_RAS) begin
                    d.cnt   = '0;
                    d.state = ST_PRE;
                end
            end
            ST_PRE: begin
                if (q.cnt == C_RP) begin
                    d.cnt = '0;
                    case (q.kind)
                        K_ROW: begin
                            done_o  = 1'b1;
                            d.row   = q.row + 1'b1;
                            d.state = ST_IDLE;
                        end
                        K_BURST_IN: begin
                            d.state = ST_CSET;
                            if (q.left == '0) begin
                                d.kind  = K_ENTRY;
                                clear_o = 1'b1;
                            end else begin
                                d.left = q.left - 1'b1;
                            end
                        end
                        K_BURST_OUT: begin
                            if (q.left == '0) begin
                                clear_o = 1'b1;
                                d.state = ST_IDLE;
                            end else begin
                                d.left  = q.left - 1'b1;
                                d.state = ST_CSET;
                            end
                        end
                        default: begin
                            done_o  = 1'b1;
                            d.state = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_SR: begin
                d.cnt = '0;
                if (!sr_req_i) begin
                    d.state = ST_SR_EXIT;
                    d.kind  = K_BURST_OUT;
                    d.left  = '1;
                end
            end
            ST_SR_EXIT: begin
                if (q.cnt == C_RPS) begin
                    d.cnt   = '0;
                    d.state = ST_CSET;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        d.pins = pins_for(d.state, d.kind);

        ras_n_o     = q.pins.ras_n;
        cas_n_o     = q.pins.cas_n;
        drive_o     = q.pins.drive;
        sr_active_o = q.pins.sr_active;
        addr_o      = q.row;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.state <= ST_IDLE;
            q.kind  <= K_CBR;
            q.cnt   <= '0;
            q.left  <= '0;
            q.row   <= '0;
            q.pins  <= '{ras_n: 1'b1, cas_n: 1'b1, drive: 1'b0, sr_active: 1'b0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int ROW_BITS = 12,
    parameter int INTERVAL = 3120,
    parameter int MAX_OWED = 8,
    parameter int T_CSR    = 1,
    parameter int T_RAS    = 12,
    parameter int T_RP     = 8,
    parameter int T_SRE    = 20100,
    parameter int T_RPS    = 22
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                mode_row_i,
    input  logic                sr_req_i,
    input  logic                gnt_i,
    output logic                req_o,
    output logic                urgent_o,
    output logic                drive_o,
    output logic                ras_n_o,
    output logic                cas_n_o,
    output logic                we_n_o,
    output logic [ROW_BITS-1:0] addr_o,
    output logic                sr_active_o
);
    logic tick, hold, clear, done, pending;

    rfs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hold_i  (hold),
        .clear_i (clear),
        .tick_o  (tick)
    );

    rfs_owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (tick),
        .dec_i     (done),
        .clear_i   (clear),
        .pending_o (pending),
        .full_o    (urgent_o)
    );

    rfs_strobe_fsm #(
        .ROW_BITS (ROW_BITS),
        .T_CSR    (T_CSR),
        .T_RAS    (T_RAS),
        .T_RP     (T_RP),
        .T_SRE    (T_SRE),
        .T_RPS    (T_RPS)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_row_i  (mode_row_i),
        .sr_req_i    (sr_req_i),
        .gnt_i       (gnt_i),
        .pending_i   (pending),
        .req_o       (req_o),
        .done_o      (done),
        .clear_o     (clear),
        .hold_o      (hold),
        .ras_n_o     (ras_n_o),
        .cas_n_o     (cas_n_o),
        .drive_o     (drive_o),
        .sr_active_o (sr_active_o),
        .addr_o      (addr_o)
    );

    assign we_n_o = 1'b1;

endmodule

// File: rtl/rfs_sched_checker.sv
module rfs_sched_checker #(
    parameter int ROW_BITS = 12
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                gnt_i,
    input logic                req_o,
    input logic                urgent_o,
    input logic                drive_o,
    input logic                ras_n_o,
    input logic                cas_n_o,
    input logic [ROW_BITS-1:0] addr_o,
    input logic                sr_active_o
);
    a_r1_released_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drive_o |-> (ras_n_o && cas_n_o && !sr_active_o));

    a_r6_drive_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(drive_o) |-> $past(gnt_i && req_o));

    a_r4_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));

    a_r5_row_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o));

    a_r7_precharge_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ras_n_o) |=> ras_n_o);

    a_r8_sr_strobes_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sr_active_o |-> (!ras_n_o && !cas_n_o && drive_o));

    a_r3_urgent_owns_or_asks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        urgent_o |-> (req_o || drive_o));

    a_r9_exit_raises_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sr_active_o) |-> (ras_n_o && cas_n_o));

endmodule

bind dram_refresh_sched rfs_sched_checker #(.ROW_BITS(ROW_BITS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_i       (gnt_i),
    .req_o       (req_o),
    .urgent_o    (urgent_o),
    .drive_o     (drive_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .addr_o      (addr_o),
    .sr_active_o (sr_active_o)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
    localparam int ROW_BITS = 3;
    localparam int INTERVAL = 200;
    localparam int MAX_OWED = 4;
    localparam int T_CSR    = 2;
    localparam int T_RAS    = 6;
    localparam int T_RP     = 4;
    localparam int T_SRE    = 30;
    localparam int T_RPS    = 10;
    localparam int ROWS     = 1 << ROW_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_row = 1'b0, sr_req = 1'b0, gnt = 1'b0;
    logic req, urgent, drive, ras_n, cas_n, we_n, sr_active;
    logic [ROW_BITS-1:0] addr;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .ROW_BITS(ROW_BITS), .INTERVAL(INTERVAL), .MAX_OWED(MAX_OWED),
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_SRE(T_SRE), .T_RPS(T_RPS)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_row_i(mode_row), .sr_req_i(sr_req),
        .gnt_i(gnt), .req_o(req), .urgent_o(urgent), .drive_o(drive),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr),
        .sr_active_o(sr_active)
    );

    int n_checks = 0, n_fails = 0, cyc = 0;

    // Pin monitor, sampled on the falling clock edge.
    int fall_cnt = 0, cbr_cnt = 0, lo_run = 0, hi_run = 0, cas_run = 0;
    int last_lo = 0, fall_setup = 0, hi_at_fall = 0, drive_run = 0, last_drive = 0;
    logic fall_cas = 1'b1, p_ras = 1'b1, p_drive = 1'b0;
    logic [ROW_BITS-1:0] fall_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ras_n) begin
                if (p_ras) begin
                    fall_cnt++;
                    fall_setup = cas_run;
                    fall_cas   = cas_n;
                    fall_addr  = addr;
                    hi_at_fall = hi_run;
                    if (!cas_n) cbr_cnt++;
                    lo_run = 1;
                end else lo_run++;
                hi_run = 0;
            end else begin
                if (!p_ras) last_lo = lo_run;
                hi_run++;
            end
            if (cas_n) cas_run = 0;
            else if (ras_n) cas_run++;
            if (drive) drive_run++;
            else begin
                if (p_drive) last_drive = drive_run;
                drive_run = 0;
            end
            p_ras   = ras_n;
            p_drive = drive;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic wait_fall;
        int f0 = fall_cnt;
        while (fall_cnt == f0) tick();
    endtask

    task automatic wait_drive_low;
        tick();
        while (drive) tick();
    endtask

    // R1 and R2: reset state, then first refresh owed after INTERVAL cycles
    task automatic t_reset_and_interval;
        int n = 0;
        repeat (5) tick();
        check(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        check(!drive && !req && !urgent && !sr_active, "R1 outputs low in reset",
              {drive, req, urgent, sr_active}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        while (!req) begin
            @(negedge clk);
            n++;
        end
        check(n == INTERVAL, "R2 first request delay", n, INTERVAL);
    endtask

    // R3, R4, R7: saturation, urgent flag, CBR strobe sequence
    task automatic t_saturate;
        int n = 0, f0;
        while (!urgent) begin
            tick();
            n++;
        end
        check(n == (MAX_OWED - 1) * INTERVAL, "R3 urgent rise delay", n, (MAX_OWED - 1) * INTERVAL);
        repeat (2 * INTERVAL + 10) tick();
        check(urgent && req && !drive, "R3 urgent held at ceiling", {urgent, req, drive}, 6);
        f0 = fall_cnt;
        gnt = 1'b1;
        tick();
        while (req || drive) tick();
        gnt = 1'b0;
        check(fall_cnt - f0 == MAX_OWED, "R3 refreshes after saturation", fall_cnt - f0, MAX_OWED);
        check(!urgent, "R3 urgent cleared", urgent, 0);
        check(fall_setup == T_CSR, "R4 CAS setup before RAS", fall_setup, T_CSR);
        check(!fall_cas, "R4 CAS low at RAS fall", fall_cas, 0);
        check(last_lo == T_RAS, "R4 RAS low width", last_lo, T_RAS);
        check(we_n, "R4 WE high", we_n, 1);
        check(last_drive == T_CSR + T_RAS + T_RP, "R7 CBR drive span", last_drive,
              T_CSR + T_RAS + T_RP);
    endtask

    // R6: nothing driven until grant, then first RAS-only cycle
    task automatic t_grant_wait(inout int exp_row);
        bit ok = 1'b1;
        while (!req) tick();
        mode_row = 1'b1;
        repeat (30) begin
            tick();
            if (drive || !ras_n || !cas_n || !req) ok = 1'b0;
        end
        check(ok, "R6 bus untouched without grant", ok, 1);
        gnt = 1'b1;
        tick();
        check(!req && drive, "R6 request drops on taking bus", {req, drive}, 1);
        wait_drive_low();
        check(last_drive == T_RAS + T_RP, "R7 RAS-only drive span", last_drive, T_RAS + T_RP);
        check(fall_cas && fall_addr == ROW_BITS'(exp_row), "R5 first RAS-only row",
              fall_addr, exp_row);
        exp_row = (exp_row + 1) % ROWS;
    endtask

    // R5: row counter advances and wraps
    task automatic t_row_wrap(inout int exp_row);
        for (int i = 0; i < ROWS + 1; i++) begin
            wait_fall();
            check(fall_cas, "R5 CAS high in RAS-only", fall_cas, 1);
            check(fall_addr == ROW_BITS'(exp_row), "R5 row sequence", fall_addr, exp_row);
            exp_row = (exp_row + 1) % ROWS;
        end
        wait_drive_low();
        check(hi_run >= 2, "R7 precharge after RAS-only", hi_run, 2);
    endtask

    // R8, R9, R10: self-refresh entry, residency, exit burst, timer restart
    task automatic t_self_refresh;
        int f0 = fall_cnt, c0 = cbr_cnt, n = 0;
        bit ok = 1'b1;
        sr_req = 1'b1;
        tick();
        while (!sr_active) tick();
        check(fall_cnt - f0 == ROWS + 1, "R8 burst plus entry falls", fall_cnt - f0, ROWS + 1);
        check(cbr_cnt - c0 == ROWS + 1, "R8 burst uses CBR in RAS-only mode", cbr_cnt - c0, ROWS + 1);
        check(lo_run >= T_SRE, "R8 entry RAS low length", lo_run, T_SRE);
        repeat (3 * INTERVAL) begin
            tick();
            if (ras_n || cas_n || !sr_active || req || urgent) ok = 1'b0;
        end
        check(ok, "R8 R10 held in self-refresh, nothing owed", ok, 1);
        f0 = fall_cnt;
        c0 = cbr_cnt;
        sr_req = 1'b0;
        tick();
        check(!sr_active && ras_n && cas_n, "R9 exit raises strobes", {sr_active, ras_n, cas_n}, 3);
        wait_fall();
        check(hi_at_fall >= T_RPS, "R9 exit precharge", hi_at_fall, T_RPS);
        wait_drive_low();
        check(fall_cnt - f0 == ROWS, "R9 exit burst length", fall_cnt - f0, ROWS);
        check(cbr_cnt - c0 == ROWS, "R9 exit burst is CBR", cbr_cnt - c0, ROWS);
        check(!req && !urgent, "R10 nothing owed after exit", {req, urgent}, 0);
        while (!req) begin
            @(negedge clk);
            n++;
        end
        check(n == INTERVAL, "R10 timer restarts after exit", n, INTERVAL);
        gnt = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int exp_row = 0;
        t_reset_and_interval();
        t_saturate();
        t_grant_wait(exp_row);
        t_row_wrap(exp_row);
        t_self_refresh();
        repeat (5) tick();
        finish_run();
    end

endmodule